// File: doc/BRIEF.md
# Sleep and Interrupt Wake-Up Controller

This block sits next to a small microcontroller core and handles what happens when the core decodes a sleep instruction. Pending work is detected by ANDing each interrupt flag with its enable. Core sources count on their own. Peripheral sources count only when the peripheral enable is also set. The global interrupt enable plays no part in detection.

If a wake source is already pending when the sleep instruction executes, the instruction does nothing. Otherwise the block clears the watchdog, updates the power-down and time-out status bits, and halts the core. The return address is frozen at the sleep address plus one.

All decisions are taken at instruction-cycle boundaries, meaning the clock edge that ends the fourth phase. On wake-up, the core first runs the instruction after the sleep in line. If the global enable is set, that instruction is followed by one dummy cycle and a redirect to the interrupt vector. If it is clear, execution simply continues in line.

Top module: `slpwake_ctl`

## Requirements
- R1: After synchronous reset, pd_bit and to_bit are 1, and halt, wdt_clr, vec_req and dummy_cyc are 0.
- R2: A wake source exists when any core_flag bit and its core_en bit are both 1, whatever peie and gie hold. It also exists when peie is 1 and any per_flag bit and its per_en bit are both 1. A peripheral source with peie at 0 does not count.
- R3: A sleep_req sampled at a boundary while a wake source exists acts as a no-op. Halt stays 0, wdt_clr stays 0, and pd_bit and to_bit keep their values.
- R4: A sleep_req sampled at a boundary with no wake source does four things from that edge: it asserts halt, drives pd_bit to 0, drives to_bit to 1, and pulses wdt_clr high for exactly one clock.
- R5: While halted, fetch_addr holds sleep_pc + 1 as captured at the sleep boundary, and halt stays 1 until a wake source is seen.
- R6: At the first boundary with halt 1 and a wake source present, halt drops to 0. One in-line instruction cycle follows, with fetch_addr still sleep_pc + 1 and pd_bit still 0.
- R7: If gie is 1 at the boundary that ends that in-line cycle, one dummy cycle follows. During it dummy_cyc and vec_req are 1 and fetch_addr equals VEC_ADDR (default 4). Both strobes return to 0 at the next boundary.
- R8: If gie is 0 at the boundary that ends that in-line cycle, no dummy cycle occurs and vec_req stays 0.
- R9: A clrwdt_req sampled at a boundary outside sleep sets pd_bit and to_bit to 1 and pulses wdt_clr for one clock. A wdt_expired pulse outside such an event clears to_bit.
- R10: Boundaries are the clock edges at which qphase equals 3 (phase Q4; Q1..Q4 are encoded 0..3). Halt and the sequence state change at no other edge, even when a wake source appears mid-cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| qphase | input | 2 | Current phase of the instruction cycle, 0..3 for Q1..Q4 |
| sleep_req | input | 1 | Sleep instruction in execution |
| clrwdt_req | input | 1 | Watchdog-clear instruction in execution |
| wdt_expired | input | 1 | Watchdog time-out pulse, clears to_bit |
| sleep_pc | input | AW | Address of the sleep instruction |
| core_flag | input | N_CORE | Core interrupt flags |
| core_en | input | N_CORE | Core interrupt enables |
| per_flag | input | N_PERIPH | Peripheral interrupt flags |
| per_en | input | N_PERIPH | Peripheral interrupt enables |
| gie | input | 1 | Global interrupt enable |
| peie | input | 1 | Peripheral interrupt enable |
| halt | output | 1 | Core halted in low-power state |
| wdt_clr | output | 1 | One-clock watchdog and prescaler clear |
| pd_bit | output | 1 | Power-down status, 0 after a real sleep |
| to_bit | output | 1 | Time-out status, 0 after a watchdog expiry |
| vec_req | output | 1 | Redirect fetch to the interrupt vector |
| dummy_cyc | output | 1 | Dummy cycle being inserted |
| fetch_addr | output | AW | Resume address while halted or vectoring |

## Verification
The bench builds the block with N_CORE = 3, N_PERIPH = 4 and AW = 8, which keeps the source vectors short enough to light single bits in each group. The peripheral gate can be exercised with one core source idle. It drives a free-running phase counter, so wake sources appear both at and between boundaries. This makes the one-boundary resolution of wake-up, the in-line versus vectored resume, and the pre-pending no-op all observable through PD, TO, the watchdog pulse and fetch_addr.

// File: rtl/slpwake_pkg.sv
package slpwake_pkg;

    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_ASLEEP = 2'd1,
        ST_RESUME = 2'd2,
        ST_DUMMY  = 2'd3
    } slp_state_e;

    localparam logic [1:0] PHASE_LAST = 2'd3;

    function automatic logic phase_end(input logic [1:0] ph);
        return ph == PHASE_LAST;
    endfunction

endpackage

// File: rtl/slpwake_src.sv
module slpwake_src #(
    parameter int N_CORE   = 3,
    parameter int N_PERIPH = 8
) (
    input  logic [N_CORE-1:0]   core_flag,
    input  logic [N_CORE-1:0]   core_en,
    input  logic [N_PERIPH-1:0] per_flag,
    input  logic [N_PERIPH-1:0] per_en,
    input  logic                peie,
    output logic                wake
);
    logic [N_CORE-1:0]   core_hit;
    logic [N_PERIPH-1:0] per_hit;

    for (genvar i = 0; i < N_CORE; i++) begin : g_core
        assign core_hit[i] = core_flag[i] & core_en[i];
    end

    for (genvar j = 0; j < N_PERIPH; j++) begin : g_per
        assign per_hit[j] = per_flag[j] & per_en[j] & peie;
    end

    assign wake = (|core_hit) | (|per_hit);
endmodule

// File: rtl/slpwake_status.sv
module slpwake_status (
    input  logic clk,
    input  logic rst,
    input  logic enter_sleep,
    input  logic clr_cmd,
    input  logic expired,
    output logic pd_q,
    output logic to_q,
    output logic clr_pulse
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pd_q      <= 1'b1;
            to_q      <= 1'b1;
            clr_pulse <= 1'b0;
        end else begin
            clr_pulse <= enter_sleep | clr_cmd;
            if (enter_sleep) begin
                pd_q <= 1'b0;
                to_q <= 1'b1;
            end else if (clr_cmd) begin
                pd_q <= 1'b1;
                to_q <= 1'b1;
            end else if (expired) begin
                to_q <= 1'b0;
            end
        end
    end

    AST_CLR_SETS_TO: assert property (@(posedge clk) disable iff (rst)
        clr_pulse |-> to_q) else $error("watchdog clear without TO set"); // R4
endmodule

// File: rtl/slpwake_ctl.sv
module slpwake_ctl
    import slpwake_pkg::*;
#(
    parameter int N_CORE   = 3,
    parameter int N_PERIPH = 8,
    parameter int AW       = 13,
    parameter int VEC_ADDR = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [1:0]          qphase,
    input  logic                sleep_req,
    input  logic                clrwdt_req,
    input  logic                wdt_expired,
    input  logic [AW-1:0]       sleep_pc,
    input  logic [N_CORE-1:0]   core_flag,
    input  logic [N_CORE-1:0]   core_en,
    input  logic [N_PERIPH-1:0] per_flag,
    input  logic [N_PERIPH-1:0] per_en,
    input  logic                gie,
    input  logic                peie,
    output logic                halt,
    output logic                wdt_clr,
    output logic                pd_bit,
    output logic                to_bit,
    output logic                vec_req,
    output logic                dummy_cyc,
    output logic [AW-1:0]       fetch_addr
);
    localparam logic [AW-1:0] VEC = AW'(VEC_ADDR);

    slp_state_e    state;
    logic [AW-1:0] pc_hold;
    logic          tick;
    logic          wake;
    logic          enter_sleep;
    logic          clr_cmd;

    slpwake_src #(.N_CORE(N_CORE), .N_PERIPH(N_PERIPH)) u_src (
        .core_flag (core_flag),
        .core_en   (core_en),
        .per_flag  (per_flag),
        .per_en    (per_en),
        .peie      (peie),
        .wake      (wake)
    );

    assign tick        = phase_end(qphase);
    assign enter_sleep = tick && (state == ST_RUN) && sleep_req && !clrwdt_req && !wake;
    assign clr_cmd     = tick && (state != ST_ASLEEP) && clrwdt_req;

    slpwake_status u_stat (
        .clk         (clk),
        .rst         (rst),
        .enter_sleep (enter_sleep),
        .clr_cmd     (clr_cmd),
        .expired     (wdt_expired),
        .pd_q        (pd_bit),
        .to_q        (to_bit),
        .clr_pulse   (wdt_clr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_RUN;
            pc_hold <= '0;
        end else if (tick) begin
            unique case (state)
                ST_RUN: if (enter_sleep) begin
                    state   <= ST_ASLEEP;
                    pc_hold <= sleep_pc + AW'(1);
                end
                ST_ASLEEP: if (wake) state <= ST_RESUME;
                ST_RESUME: state <= gie ? ST_DUMMY : ST_RUN;
                ST_DUMMY:  state <= ST_RUN;
                default:   state <= ST_RUN;
            endcase
        end
    end

    assign halt       = (state == ST_ASLEEP);
    assign dummy_cyc  = (state == ST_DUMMY);
    assign vec_req    = (state == ST_DUMMY);
    assign fetch_addr = (state == ST_DUMMY) ? VEC : pc_hold;

    AST_SLEEP_STATUS: assert property (@(posedge clk) disable iff (rst)
        $rose(halt) |-> (!pd_bit && to_bit && wdt_clr)) else $error("sleep entry status"); // R4
    AST_NOP_KEEPS_PD: assert property (@(posedge clk) disable iff (rst)
        $fell(pd_bit) |-> $past(!wake)) else $error("PD cleared with wake pending"); // R3
    AST_WAKE_NEEDS_SRC: assert property (@(posedge clk) disable iff (rst)
        $fell(halt) |-> $past(wake)) else $error("wake without source"); // R6
    AST_DUMMY_NEEDS_GIE: assert property (@(posedge clk) disable iff (rst)
        $rose(dummy_cyc) |-> $past(gie)) else $error("dummy cycle with gie clear"); // R7
    AST_BOUNDARY_ONLY: assert property (@(posedge clk) disable iff (rst)
        !$past(tick) |-> $stable(state)) else $error("state moved off boundary"); // R10
endmodule

// File: tb/tb_slpwake_ctl.sv
module tb_slpwake_ctl;
    localparam int NC = 3;
    localparam int NP = 4;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [1:0]    ph  = 2'd0;
    logic          sleep_req = 1'b0, clrwdt_req = 1'b0, wdt_expired = 1'b0;
    logic [AW-1:0] sleep_pc = '0;
    logic [NC-1:0] core_flag = '0, core_en = '0;
    logic [NP-1:0] per_flag = '0, per_en = '0;
    logic          gie = 1'b0, peie = 1'b0;
    logic          halt, wdt_clr, pd_bit, to_bit, vec_req, dummy_cyc;
    logic [AW-1:0] fetch_addr;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    always @(negedge clk) begin
        if (rst) ph <= 2'd0;
        else     ph <= ph + 2'd1;
    end

    slpwake_ctl #(.N_CORE(NC), .N_PERIPH(NP), .AW(AW), .VEC_ADDR(4)) dut (
        .clk(clk), .rst(rst), .qphase(ph), .sleep_req(sleep_req),
        .clrwdt_req(clrwdt_req), .wdt_expired(wdt_expired), .sleep_pc(sleep_pc),
        .core_flag(core_flag), .core_en(core_en), .per_flag(per_flag), .per_en(per_en),
        .gie(gie), .peie(peie), .halt(halt), .wdt_clr(wdt_clr), .pd_bit(pd_bit),
        .to_bit(to_bit), .vec_req(vec_req), .dummy_cyc(dummy_cyc), .fetch_addr(fetch_addr)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // advance to just after the next boundary edge (qphase == 3)
    task automatic boundary();
        do begin
            @(negedge clk); #1;
        end while (ph != 2'd3);
        @(posedge clk); #1;
    endtask

    task automatic clear_srcs();
        core_flag = '0; core_en = '0; per_flag = '0; per_en = '0;
        gie = 1'b0; peie = 1'b0;
    endtask

    task automatic restore_status();
        clrwdt_req = 1'b1;
        boundary();
        clrwdt_req = 1'b0;
        chk("R9 clrwdt pd", pd_bit, 1);
        chk("R9 clrwdt to", to_bit, 1);
        chk("R9 clrwdt pulse", wdt_clr, 1);
        @(posedge clk); #1;
        chk("R9 pulse one clock", wdt_clr, 0);
    endtask

    task automatic t_reset();
        chk("R1 pd", pd_bit, 1);
        chk("R1 to", to_bit, 1);
        chk("R1 halt", halt, 0);
        chk("R1 wdt_clr", wdt_clr, 0);
        chk("R1 vec_req", vec_req, 0);
        chk("R1 dummy", dummy_cyc, 0);
    endtask

    task automatic t_prepending();
        wdt_expired = 1'b1;
        @(posedge clk); #1;
        wdt_expired = 1'b0;
        chk("R9 expiry clears to", to_bit, 0);
        core_flag = 3'b010; core_en = 3'b010; gie = 1'b0;
        sleep_pc = 8'h40; sleep_req = 1'b1;
        boundary();
        sleep_req = 1'b0;
        chk("R3 nop halt", halt, 0);
        chk("R3 nop wdt_clr", wdt_clr, 0);
        chk("R3 nop pd", pd_bit, 1);
        chk("R3 nop to", to_bit, 0);
        boundary();
        chk("R3 still running", halt, 0);
        clear_srcs();
        restore_status();
    endtask

    task automatic t_wake_gie1();
        gie = 1'b1;
        sleep_pc = 8'h20; sleep_req = 1'b1;
        boundary();
        sleep_req = 1'b0;
        chk("R4 halt", halt, 1);
        chk("R4 pd", pd_bit, 0);
        chk("R4 to", to_bit, 1);
        chk("R4 wdt_clr", wdt_clr, 1);
        @(posedge clk); #1;
        chk("R4 pulse one clock", wdt_clr, 0);
        boundary();
        chk("R5 held", halt, 1);
        chk("R5 frozen pc", fetch_addr, 8'h21);
        // R10: source appears right after a boundary; no change until next one
        core_flag = 3'b001; core_en = 3'b001;
        for (int k = 0; k < 3; k++) begin
            @(posedge clk); #1;
            chk("R10 no mid-cycle wake", halt, 1);
        end
        @(posedge clk); #1;
        chk("R6 wake halt", halt, 0);
        chk("R6 inline pc", fetch_addr, 8'h21);
        chk("R6 pd kept", pd_bit, 0);
        chk("R6 no dummy yet", dummy_cyc, 0);
        boundary();
        chk("R7 dummy", dummy_cyc, 1);
        chk("R7 vec_req", vec_req, 1);
        chk("R7 vector", fetch_addr, 8'h04);
        boundary();
        chk("R7 dummy ends", dummy_cyc, 0);
        chk("R7 vec ends", vec_req, 0);
        clear_srcs();
        restore_status();
    endtask

    task automatic t_wake_gie0();
        gie = 1'b0;
        sleep_pc = 8'h7e; sleep_req = 1'b1;
        boundary();
        sleep_req = 1'b0;
        chk("R4 halt gie0", halt, 1);
        core_flag = 3'b100; core_en = 3'b100;
        boundary();
        chk("R6 wake gie0", halt, 0);
        chk("R6 inline pc gie0", fetch_addr, 8'h7f);
        boundary();
        chk("R8 no dummy", dummy_cyc, 0);
        chk("R8 no vec", vec_req, 0);
        boundary();
        chk("R8 no vec later", vec_req, 0);
        clear_srcs();
        restore_status();
    endtask

    task automatic t_periph_gate();
        per_flag = 4'b1000; per_en = 4'b1000; peie = 1'b0;
        core_flag = 3'b011; core_en = 3'b100;
        sleep_pc = 8'h10; sleep_req = 1'b1;
        boundary();
        sleep_req = 1'b0;
        chk("R2 peie gate sleeps", halt, 1);
        chk("R2 pd after sleep", pd_bit, 0);
        boundary();
        chk("R2 gated stays asleep", halt, 1);
        peie = 1'b1;
        boundary();
        chk("R2 peie opens wake", halt, 0);
        boundary();
        clear_srcs();
        restore_status();
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_prepending();
        t_wake_gie1();
        t_wake_gie0();
        t_periph_gate();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #200000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule